// File: doc/BRIEF.md
# Serial Wiper Register Interface

This block is the digital control core of a serially programmed potentiometer. A host selects it with a chip-select line and clocks in frames on a serial data input. Each frame has a start bit, a two-bit device address and an eight-bit wiper setting. While the new setting shifts in, the old wiper value shifts out on the serial data output. Every write therefore also reads the old value, and the read is destructive. The wiper register drives the potentiometer tap on `wiper_o`. A valid frame changes that output at once, as a temporary setting. The setting holds only as long as chip-select stays high.

Behind the wiper sits a non-volatile store, modelled as a register that takes a fixed number of cycles to write. The wiper reloads from the store every cycle that chip-select is low. Dropping chip-select therefore cancels a temporary setting, or restores a value that a partial frame has shifted away. To keep a new setting, the host raises the program strobe within a short window after the frame that carried it. Ready/busy then goes low for the write time, and the store takes the new value. The serial clock is taken to be synchronous to the core clock and is edge-detected inside the block.

Top module: `serial_wiper_core`

## Requirements
- R1: After reset, `wiper_o` and the store hold the FACTORY value (default 0x80), `rdy` is 1 and `sdo` is 0.
- R2: A frame is 11 bits, each sampled on a rising edge of `sclk` while `cs` is high. Bit 0 is the start bit. Bits 1 and 2 are address bits A0 then A1. Bits 3 to 10 are data D0 to D7, least significant first. When the start bit is 1 and {A1,A0} equals DEV_ADDR (default 2'b10), `wiper_o` equals the data one clock after the eleventh edge.
- R3: Before the rising edge of data bit k (k = 0..7), `sdo` shows bit k of the wiper value held at the start of that frame. `sdo` is 0 during the header bits and while `cs` is low.
- R4: While `cs` stays high, the bit after an eleventh bit starts a new frame. Each valid frame replaces the wiper value, any number of times.
- R5: While `cs` is low, `wiper_o` equals the store value one clock later. This also holds after a partial, read-only frame.
- R6: A frame whose start bit is 0, or whose address differs from DEV_ADDR, leaves `wiper_o` unchanged at its end. `sdo` still shows the current value.
- R7: The bit position restarts at 0 whenever `cs` rises, whatever state an earlier partial frame left.
- R8: `prog` is accepted if it is high on either of the PROG_WIN (2) clocks that follow the clock on which a valid frame's eleventh bit was taken. `rdy` is then low for exactly BUSY_CYC (16) cycles, and the store then holds that frame's data.
- R9: `prog` is ignored in three cases: when it comes later than the window, when no valid frame is pending, and while busy. In each case `rdy` stays high and the store keeps its value.
- R10: The store changes only on the cycle in which `rdy` returns high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs | input | 1 | Chip-select, active high |
| sclk | input | 1 | Serial clock, sampled on its rising edge |
| di | input | 1 | Serial data input |
| sdo | output | 1 | Serial data output: old wiper bits |
| prog | input | 1 | Program strobe: commit pending data to the store |
| rdy | output | 1 | Ready (1) / busy (0) |
| wiper_o | output | 8 | Current wiper setting |

## Verification
The bench checks the prog window at both edges. A strobe one clock late must be accepted and a strobe two clocks late refused. A design with a wrong window length would either drop a valid commit or store stale data. Partial frames are cut off at random bit positions and then dropped with chip-select. A design that failed to reload the wiper or to restart the bit count would then misload the next frame, or show a wiper value part-way through a shift. Header-rejected frames and back-to-back frames under one chip-select are compared bit by bit on `sdo`. An error in the recirculation or in the wrap of the bit count would corrupt the old value read out, or leave a rejected frame's data on the wiper.

// File: rtl/swr_pkg.sv
// Package: shared types and helpers for the serial wiper register core.
// Assumes nothing beyond IEEE 1800-2017 constant functions.
package swr_pkg;

    // Which part of an 11-bit frame the next serial bit belongs to.
    typedef enum logic [0:0] {
        PH_HEADER = 1'b0,
        PH_DATA   = 1'b1
    } frame_phase_e;

    // Frame length: one start bit, the address, then the data.
    function automatic int frame_len(input int addr_w, input int data_w);
        return 1 + addr_w + data_w;
    endfunction

endpackage

// File: rtl/swr_frame_ctl.sv
// Module: serial frame sequencer.
// Edge-detects sclk, counts the bits of a frame, captures the header and
// decides whether the frame is addressed to this device.
// Assumes sclk is synchronous to clk and stays high or low for at least one clk.
module swr_frame_ctl #(
    parameter int unsigned ADDR_W   = 2,
    parameter int unsigned DATA_W   = 8,
    parameter int unsigned DEV_ADDR = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cs,
    input  logic                   sclk,
    input  logic                   di,
    output logic                   shift_en,
    output logic                   hit,
    output logic                   frame_done,
    output swr_pkg::frame_phase_e  phase
);
    import swr_pkg::*;

    localparam int unsigned HDR_W      = 1 + ADDR_W;
    localparam int unsigned FRAME_BITS = frame_len(ADDR_W, DATA_W);
    localparam int unsigned CNT_W      = $clog2(FRAME_BITS + 1);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_BITS - 1);
    localparam logic [CNT_W-1:0] HDR_END  = CNT_W'(HDR_W);

    logic              sclk_q;
    logic              sck_rise;
    logic [CNT_W-1:0]  bit_cnt;
    logic [HDR_W-1:0]  hdr;

    // Remember last sclk level for rising-edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sclk_q <= 1'b0;
        else        sclk_q <= sclk;
    end

    assign sck_rise = cs && sclk && !sclk_q;

    // Bit position within the frame; cleared while deselected, wraps after the last bit.
    always_ff @(posedge clk) begin
        if (!rst_n || !cs)  bit_cnt <= '0;
        else if (sck_rise)  bit_cnt <= (bit_cnt == LAST_BIT) ? '0 : bit_cnt + 1'b1;
    end

    // Shift the start and address bits in; first bit ends at hdr[0].
    always_ff @(posedge clk) begin
        if (!rst_n)                              hdr <= '0;
        else if (sck_rise && bit_cnt < HDR_END)  hdr <= {di, hdr[HDR_W-1:1]};
    end

    // Classify the current position and decode the header.
    always_comb begin
        phase      = (bit_cnt >= HDR_END) ? PH_DATA : PH_HEADER;
        hit        = hdr[0] && (hdr[HDR_W-1:1] == DEV_ADDR[ADDR_W-1:0]);
        shift_en   = sck_rise && (phase == PH_DATA);
        frame_done = shift_en && hit && (bit_cnt == LAST_BIT);
    end

    // R7
    cnt_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs) |-> bit_cnt == '0);

    // R2
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bit_cnt <= LAST_BIT);

endmodule

// File: rtl/swr_wiper_reg.sv
// Module: volatile wiper register and serial read-out.
// The register is its own shift register: each data bit shifts it right,
// sending the old LSB to sdo and taking either the new bit (matching frame)
// or the bit just sent (rejected frame, recirculated). While deselected it
// reloads from the non-volatile store every cycle.
module swr_wiper_reg #(
    parameter int unsigned        DATA_W  = 8,
    parameter logic [DATA_W-1:0]  FACTORY = 8'h80
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cs,
    input  logic                   shift_en,
    input  logic                   hit,
    input  logic                   di,
    input  swr_pkg::frame_phase_e  phase,
    input  logic [DATA_W-1:0]      nv,
    output logic [DATA_W-1:0]      wiper,
    output logic [DATA_W-1:0]      wiper_nxt,
    output logic                   sdo
);
    import swr_pkg::*;

    // Next value while selected: shift on a data bit, else hold.
    always_comb begin
        wiper_nxt = wiper;
        if (shift_en) wiper_nxt = {(hit ? di : wiper[0]), wiper[DATA_W-1:1]};
    end

    // Wiper state: factory on reset, store while deselected, shift while selected.
    always_ff @(posedge clk) begin
        if (!rst_n)   wiper <= FACTORY;
        else if (!cs) wiper <= nv;
        else          wiper <= wiper_nxt;
    end

    // Serial output: old LSB during data bits only.
    assign sdo = (cs && phase == PH_DATA) ? wiper[0] : 1'b0;

    // R5
    reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cs |=> wiper == $past(nv));

endmodule

// File: rtl/swr_prog_ctl.sv
// Module: programming window, busy timer and non-volatile store.
// A valid frame leaves its data pending for PROG_WIN clocks. A prog strobe in
// that window starts a BUSY_CYC-cycle write, after which the store updates.
// Assumes frame_done is a single-cycle pulse and new_data is valid with it.
module swr_prog_ctl #(
    parameter int unsigned        DATA_W   = 8,
    parameter logic [DATA_W-1:0]  FACTORY  = 8'h80,
    parameter int unsigned        PROG_WIN = 2,
    parameter int unsigned        BUSY_CYC = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cs,
    input  logic               prog,
    input  logic               frame_done,
    input  logic [DATA_W-1:0]  new_data,
    output logic [DATA_W-1:0]  nv,
    output logic               rdy
);
    localparam int unsigned WIN_W  = $clog2(PROG_WIN + 1);
    localparam int unsigned BCNT_W = $clog2(BUSY_CYC + 1);
    localparam logic [WIN_W-1:0]  WIN_LOAD  = WIN_W'(PROG_WIN);
    localparam logic [BCNT_W-1:0] BUSY_LOAD = BCNT_W'(BUSY_CYC - 1);

    logic               pend_vld;
    logic [WIN_W-1:0]   win_cnt;
    logic [DATA_W-1:0]  pend_data;
    logic [DATA_W-1:0]  commit_q;
    logic               busy;
    logic [BCNT_W-1:0]  bcnt;
    logic               accept;
    logic               write_end;

    assign accept    = pend_vld && prog && !busy;
    assign write_end = busy && (bcnt == '0);
    assign rdy       = !busy;

    // Pending data and its expiry window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_vld  <= 1'b0;
            win_cnt   <= '0;
            pend_data <= '0;
        end else if (frame_done) begin
            pend_vld  <= 1'b1;
            win_cnt   <= WIN_LOAD;
            pend_data <= new_data;
        end else if (pend_vld) begin
            if (!cs || accept || win_cnt <= 1) pend_vld <= 1'b0;
            else                               win_cnt  <= win_cnt - 1'b1;
        end
    end

    // Busy timer for the store write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            bcnt <= '0;
        end else if (accept) begin
            busy <= 1'b1;
            bcnt <= BUSY_LOAD;
        end else if (busy) begin
            if (bcnt == '0) busy <= 1'b0;
            else            bcnt <= bcnt - 1'b1;
        end
    end

    // Data latched at the strobe so later frames cannot disturb the write.
    always_ff @(posedge clk) begin
        if (!rst_n)      commit_q <= FACTORY;
        else if (accept) commit_q <= pend_data;
    end

    // Non-volatile store: updated only when the write time has elapsed.
    always_ff @(posedge clk) begin
        if (!rst_n)         nv <= FACTORY;
        else if (write_end) nv <= commit_q;
    end

    // R8
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rdy) |-> $past(prog) && $past(pend_vld));

    // R9
    stray_prog_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (prog && rdy && !pend_vld && !frame_done) |=> rdy);

    // R10
    store_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (nv != $past(nv)) |-> $rose(rdy));

    // R8
    win_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        win_cnt <= WIN_LOAD);

endmodule

// File: rtl/serial_wiper_core.sv
// Module: top of the serial wiper register interface.
// Joins the frame sequencer, the wiper register and the programming control.
// Assumes sclk and cs are synchronous to clk; reset is synchronous, active low.
module serial_wiper_core #(
    parameter int unsigned        ADDR_W   = 2,
    parameter int unsigned        DATA_W   = 8,
    parameter int unsigned        DEV_ADDR = 2,
    parameter logic [DATA_W-1:0]  FACTORY  = 8'h80,
    parameter int unsigned        PROG_WIN = 2,
    parameter int unsigned        BUSY_CYC = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cs,
    input  logic               sclk,
    input  logic               di,
    output logic               sdo,
    input  logic               prog,
    output logic               rdy,
    output logic [DATA_W-1:0]  wiper_o
);
    import swr_pkg::*;

    logic               shift_en;
    logic               hit;
    logic               frame_done;
    frame_phase_e       phase;
    logic [DATA_W-1:0]  nv;
    logic [DATA_W-1:0]  wiper_nxt;

    swr_frame_ctl #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEV_ADDR(DEV_ADDR)
    ) u_frame (
        .clk(clk), .rst_n(rst_n), .cs(cs), .sclk(sclk), .di(di),
        .shift_en(shift_en), .hit(hit), .frame_done(frame_done), .phase(phase)
    );

    swr_wiper_reg #(
        .DATA_W(DATA_W), .FACTORY(FACTORY)
    ) u_wiper (
        .clk(clk), .rst_n(rst_n), .cs(cs), .shift_en(shift_en), .hit(hit),
        .di(di), .phase(phase), .nv(nv), .wiper(wiper_o),
        .wiper_nxt(wiper_nxt), .sdo(sdo)
    );

    swr_prog_ctl #(
        .DATA_W(DATA_W), .FACTORY(FACTORY),
        .PROG_WIN(PROG_WIN), .BUSY_CYC(BUSY_CYC)
    ) u_prog (
        .clk(clk), .rst_n(rst_n), .cs(cs), .prog(prog),
        .frame_done(frame_done), .new_data(wiper_nxt), .nv(nv), .rdy(rdy)
    );

    // R3
    sdo_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs && !$past(cs)) |-> !sdo);

endmodule

// File: tb/tb_serial_wiper_core.sv
// Bench: directed corner cases plus seeded random frames, checked against
// a model of the wiper and store values kept in the bench.
module tb_serial_wiper_core;
    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] FACT = 8'h80;
    localparam logic [1:0] MYADDR = 2'b10;
    localparam int BUSY = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs = 1'b0, sclk = 1'b0, di = 1'b0, prog = 1'b0;
    logic sdo, rdy;
    logic [7:0] wiper_o;

    int checks = 0;
    int errors = 0;
    logic [7:0] exp_w = FACT;
    logic [7:0] exp_nv = FACT;
    bit pending = 0;

    serial_wiper_core dut (
        .clk(clk), .rst_n(rst_n), .cs(cs), .sclk(sclk), .di(di),
        .sdo(sdo), .prog(prog), .rdy(rdy), .wiper_o(wiper_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    function automatic logic frame_bit(input logic st, input logic [1:0] a,
                                       input logic [7:0] d, input int i);
        if (i == 0) return st;
        if (i < 3)  return a[i-1];
        return d[i-3];
    endfunction

    // Caller is at a negedge with cs high.
    task automatic send_frame(input logic st, input logic [1:0] a,
                              input logic [7:0] d, input int nbits);
        logic [7:0] oldv = exp_w;
        for (int i = 0; i < nbits; i++) begin
            di = frame_bit(st, a, d, i);
            sclk = 1'b0;
            @(negedge clk);
            if (i >= 3) check(sdo == oldv[i-3], "R3 data readout", sdo, oldv[i-3]);
            else        check(sdo == 1'b0, "R3 header quiet", sdo, 0);
            sclk = 1'b1;
            @(negedge clk);
        end
        pending = 0;
        if (nbits == 11) begin
            if (st && a == MYADDR) begin
                exp_w = d;
                pending = 1;
                check(wiper_o == exp_w, "R2 R4 load", wiper_o, exp_w);
            end else begin
                check(wiper_o == exp_w, "R6 rejected frame", wiper_o, exp_w);
            end
        end
    endtask

    task automatic drop_cs();
        cs = 1'b0; sclk = 1'b0; pending = 0;
        @(negedge clk);
        exp_w = exp_nv;
        check(wiper_o == exp_nv, "R5 reload", wiper_o, exp_nv);
        check(sdo == 1'b0, "R3 sdo idle", sdo, 0);
    endtask

    task automatic raise_cs();
        cs = 1'b1;
    endtask

    // Strobe prog after 'dly' idle clocks; measure busy length.
    task automatic do_prog(input int dly);
        int n = 0;
        bit acc = pending && (dly <= 1);
        logic [7:0] d = exp_w;
        repeat (dly) @(negedge clk);
        prog = 1'b1;
        @(negedge clk);
        prog = 1'b0;
        while (!rdy && n < 100) begin
            n++;
            @(negedge clk);
        end
        pending = 0;
        if (acc) begin
            check(n == BUSY, "R8 busy length", n, BUSY);
            exp_nv = d;
        end else begin
            check(n == 0, "R9 prog ignored", n, 0);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=expired expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int unsigned seed = $urandom(32'd4711);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        check(wiper_o == FACT, "R1 reset wiper", wiper_o, FACT);
        check(rdy == 1'b1, "R1 reset rdy", rdy, 1);
        check(sdo == 1'b0, "R1 reset sdo", sdo, 0);

        // R2, R4: two frames under one chip-select
        raise_cs();
        send_frame(1'b1, MYADDR, 8'h3C, 11);
        send_frame(1'b1, MYADDR, 8'hA5, 11);
        // R6: wrong address, then zero start bit
        send_frame(1'b1, 2'b01, 8'h12, 11);
        send_frame(1'b0, MYADDR, 8'h34, 11);
        // R5: revert temporary setting
        drop_cs();
        // R5, R7: read-only partial frame then a full frame
        raise_cs();
        send_frame(1'b1, MYADDR, 8'h11, 7);
        drop_cs();
        raise_cs();
        send_frame(1'b1, MYADDR, 8'h5A, 11);
        // R8: immediate prog
        do_prog(0);
        drop_cs();
        check(wiper_o == 8'h5A, "R10 stored value", wiper_o, 8'h5A);
        // R9: prog two clocks late
        raise_cs();
        send_frame(1'b1, MYADDR, 8'h77, 11);
        do_prog(2);
        drop_cs();
        // R8: last clock of window
        raise_cs();
        send_frame(1'b1, MYADDR, 8'h99, 11);
        do_prog(1);
        // R9: no pending frame
        do_prog(0);
        drop_cs();

        // Random frames
        for (int i = 0; i < 60; i++) begin
            logic st = ($urandom % 8) != 0;
            logic [1:0] a = (($urandom % 4) == 0) ? 2'($urandom) : MYADDR;
            logic [7:0] d = 8'($urandom);
            int nb = (($urandom % 4) == 0) ? 1 + int'($urandom % 10) : 11;
            if (!cs) raise_cs();
            send_frame(st, a, d, nb);
            if (nb < 11) drop_cs();
            else begin
                if (pending && ($urandom % 3) == 0) do_prog(int'($urandom % 3));
                if (($urandom % 3) == 0) drop_cs();
            end
        end
        if (cs) drop_cs();

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule